// File: doc/BRIEF.md
# Synchronous Burst SRAM Address Sequencer

This block sits in front of a synchronous SRAM array and produces the word address the array sees on every cycle. An external address is captured when either of two start strobes fires: a processor-side strobe and a controller-side strobe. After that, the block generates the next three addresses of a four-beat group by itself, stepping a 2-bit beat counter each time the advance input is high. All inputs are sampled on the rising clock edge, and the outputs change only after that edge.

The beat counter changes only the two low address bits. A mode input selects how those bits move. In linear order they count upward modulo four from the loaded value. In interleaved order they are the loaded value XOR the beat number. The upper address bits never change within a group. A new address may be loaded on any cycle, including in the middle of a group, so bursting is optional.

The block has two states. ST_IDLE means no access is presented. ST_BURST means an access is presented. The transition LOAD goes from ST_IDLE to ST_BURST, or restarts ST_BURST. DESELECT goes from ST_BURST to ST_IDLE. STEP stays in ST_BURST and advances the beat. HOLD stays in either state with nothing changed.

Top module: `sram_burst_addr_gen`

## Requirements
- R1: During and directly after reset, `arr_valid` and `arr_write` are 0 and `arr_addr` is all zeros.
- R2: When `start_cpu` and `chip_en` are both 1 at an edge, that edge loads `ext_addr`. After the edge, `arr_addr` equals the loaded address, `arr_valid` is 1 and `arr_write` is 0, whatever `write_req` was.
- R3: When `start_ctl` and `chip_en` are 1 and the processor strobe is not effective, that edge loads `ext_addr`. After the edge, `arr_valid` is 1 and `arr_write` equals the sampled `write_req`.
- R4: When both strobes are 1 with `chip_en` 1, the processor strobe wins, so `arr_write` is 0 even when `write_req` is 1.
- R5: `start_cpu` has no effect while `chip_en` is 0. With `start_ctl` low, the outputs behave as if `start_cpu` were low.
- R6: `start_ctl` with `chip_en` 0 performs DESELECT: after the edge, `arr_valid` and `arr_write` are 0.
- R7: With `order_linear` = 1, the two low address bits during beat n (n = 0..3) are (loaded low bits + n) mod 4.
- R8: With `order_linear` = 0, the two low address bits during beat n are the loaded low bits XOR n.
- R9: Address bits above bit 1 stay equal to the loaded value for the whole group. After four STEPs the address returns to the loaded value with no carry into the upper bits.
- R10: During ST_BURST, an edge with `adv` = 0 and no strobe keeps `arr_addr` and `arr_write` unchanged. An edge with `adv` = 1 and no strobe performs STEP, and `arr_write` takes the sampled `write_req`.
- R11: In ST_IDLE, `adv` without a strobe has no effect and `arr_valid` stays 0.
- R12: A LOAD during ST_BURST restarts at beat 0 on the new address on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External word address |
| start_cpu | input | 1 | Processor-side start strobe, gated by chip_en, highest priority |
| start_ctl | input | 1 | Controller-side start strobe; deselects when chip_en is 0 |
| chip_en | input | 1 | Chip enable |
| adv | input | 1 | Advance the beat counter during a burst |
| write_req | input | 1 | Write request sampled with controller loads and steps |
| order_linear | input | 1 | 1 selects linear order, 0 selects interleaved order (tie low by default) |
| arr_addr | output | ADDR_W | Address presented to the array |
| arr_valid | output | 1 | An access is presented this cycle |
| arr_write | output | 1 | The presented access is a write |

## Verification
A wrong beat count or a wrong stored base shows up on `arr_addr` in the first cycle after the edge that produced it. A counter that carries out of its two bits shows up in the upper bits on the fifth beat of a group. A state register stuck in the wrong state shows up on `arr_valid` one cycle after the DESELECT or LOAD that should have moved it. A priority error between the strobes shows up on `arr_write` after a dual-strobe write load.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_state_e;

    typedef struct packed {
        logic load;
        logic load_cpu;
        logic deselect;
        logic step;
    } burst_cmd_t;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import sram_burst_pkg::*;
(
    input  logic       start_cpu,
    input  logic       start_ctl,
    input  logic       chip_en,
    input  logic       adv,
    input  logic       in_burst,
    output burst_cmd_t cmd
);

    logic cpu_hit;
    logic ctl_hit;

    always_comb begin
        cpu_hit      = start_cpu & chip_en;
        ctl_hit      = start_ctl & ~cpu_hit;
        cmd.load_cpu = cpu_hit;
        cmd.load     = cpu_hit | (ctl_hit & chip_en);
        cmd.deselect = ctl_hit & ~chip_en;
        cmd.step     = ~cpu_hit & ~start_ctl & adv & in_burst;
    end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import sram_burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] beat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clear) begin
            beat <= '0;
        end else if (inc) begin
            beat <= beat + CNT_W'(1);
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import sram_burst_pkg::*;
(
    input  logic [CNT_W-1:0] base_lo,
    input  logic [CNT_W-1:0] beat,
    input  logic             order_linear,
    output logic [CNT_W-1:0] addr_lo
);

    logic [CNT_W-1:0] lin_lo;
    logic [CNT_W-1:0] ilv_lo;

    assign lin_lo = base_lo + beat;

    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_lo[b] ^ beat[b];
    end

    assign addr_lo = order_linear ? lin_lo : ilv_lo;

endmodule

// File: rtl/sram_burst_addr_gen.sv
module sram_burst_addr_gen
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              start_cpu,
    input  logic              start_ctl,
    input  logic              chip_en,
    input  logic              adv,
    input  logic              write_req,
    input  logic              order_linear,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_valid,
    output logic              arr_write
);

    localparam int UP_W = ADDR_W - CNT_W;

    burst_state_e      state_q;
    burst_state_e      state_d;
    burst_cmd_t        cmd;
    logic [ADDR_W-1:0] base_q;
    logic              write_q;
    logic [CNT_W-1:0]  beat;
    logic [CNT_W-1:0]  addr_lo;

    burst_cmd_decode u_dec (
        .start_cpu (start_cpu),
        .start_ctl (start_ctl),
        .chip_en   (chip_en),
        .adv       (adv),
        .in_burst  (state_q == ST_BURST),
        .cmd       (cmd)
    );

    burst_beat_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmd.load),
        .inc   (cmd.step),
        .beat  (beat)
    );

    burst_order_map u_map (
        .base_lo      (base_q[CNT_W-1:0]),
        .beat         (beat),
        .order_linear (order_linear),
        .addr_lo      (addr_lo)
    );

    // Next-state logic: LOAD, DESELECT, STEP/HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd.load) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (cmd.deselect) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output-side registers: captured base and write qualifier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            write_q <= 1'b0;
        end else if (cmd.load) begin
            base_q  <= ext_addr;
            write_q <= cmd.load_cpu ? 1'b0 : write_req;
        end else if (cmd.deselect) begin
            write_q <= 1'b0;
        end else if (cmd.step) begin
            write_q <= write_req;
        end
    end

    assign arr_addr  = {base_q[ADDR_W-1 -: UP_W], addr_lo};
    assign arr_valid = (state_q == ST_BURST);
    assign arr_write = write_q;

endmodule

// File: rtl/burst_addr_checker.sv
module burst_addr_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              start_cpu,
    input logic              start_ctl,
    input logic              chip_en,
    input logic              adv,
    input logic              write_req,
    input logic              order_linear,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              arr_valid,
    input logic              arr_write
);

    assert_write_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |-> !arr_write);

    assert_cpu_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_cpu && chip_en) |=> (arr_valid && !arr_write && arr_addr == $past(ext_addr)));

    assert_ctl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ctl && chip_en && !start_cpu)
        |=> (arr_valid && arr_write == $past(write_req) && arr_addr == $past(ext_addr)));

    assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ctl && !chip_en) |=> !arr_valid);

    assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !start_cpu && !start_ctl)
        |=> (arr_addr[ADDR_W-1:2] == $past(arr_addr[ADDR_W-1:2])));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !adv && !start_cpu && !start_ctl)
        |=> ((arr_addr == $past(arr_addr) || order_linear != $past(order_linear))
             && arr_write == $past(arr_write)));

    assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_valid && !start_cpu && !start_ctl) |=> !arr_valid);

endmodule

bind sram_burst_addr_gen burst_addr_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_sram_burst_addr_gen.sv
module test_sram_burst_addr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          start_cpu = 1'b0, start_ctl = 1'b0, chip_en = 1'b0;
    logic          adv = 1'b0, write_req = 1'b0, order_linear = 1'b0;
    logic [AW-1:0] arr_addr;
    logic          arr_valid, arr_write;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic          m_valid = 1'b0, m_write = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_burst_addr_gen #(.ADDR_W(AW)) i_sram_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .start_cpu(start_cpu), .start_ctl(start_ctl), .chip_en(chip_en),
        .adv(adv), .write_req(write_req), .order_linear(order_linear),
        .arr_addr(arr_addr), .arr_valid(arr_valid), .arr_write(arr_write)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] base, logic [1:0] beat, logic lin);
        logic [1:0] lo;
        lo = lin ? 2'(base[1:0] + beat) : (base[1:0] ^ beat);
        return {base[AW-1:2], lo};
    endfunction

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_model(string tag);
        check({tag, " valid"}, AW'(arr_valid), AW'(m_valid));
        check({tag, " write"}, AW'(arr_write), AW'(m_write));
        if (m_valid) check({tag, " addr"}, arr_addr, exp_addr(m_base, m_beat, order_linear));
    endtask

    // drive one cycle, update model, sample a quarter period after the edge
    task automatic cyc(logic cpu, logic ctl, logic ce, logic a, logic wr, logic [AW-1:0] ad);
        start_cpu = cpu; start_ctl = ctl; chip_en = ce; adv = a; write_req = wr; ext_addr = ad;
        if (cpu && ce) begin
            m_valid = 1; m_write = 0; m_base = ad; m_beat = 0;
        end else if (ctl && ce) begin
            m_valid = 1; m_write = wr; m_base = ad; m_beat = 0;
        end else if (ctl) begin
            m_valid = 0; m_write = 0;
        end else if (a && m_valid) begin
            m_beat = m_beat + 2'd1; m_write = wr;
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        #(CLK_PERIOD*2 + CLK_PERIOD/4);
        // R1: reset state
        check("R1 valid", AW'(arr_valid), '0);
        check("R1 write", AW'(arr_write), '0);
        check("R1 addr", arr_addr, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: advance while idle does nothing
        cyc(0, 0, 1, 1, 1, 20'h12345);
        check("R11 idle", AW'(arr_valid), '0);

        // R2 + R7: processor load, linear order from low bits 1
        order_linear = 1'b1;
        cyc(1, 0, 1, 0, 1, 20'hABC01);
        check("R2 addr", arr_addr, 20'hABC01);
        check("R2 write", AW'(arr_write), '0);
        cyc(0, 0, 1, 1, 0, '0); check("R7 beat1", arr_addr, 20'hABC02);
        cyc(0, 0, 1, 1, 0, '0); check("R7 beat2", arr_addr, 20'hABC03);
        cyc(0, 0, 1, 1, 0, '0); check("R7 beat3", arr_addr, 20'hABC00);
        cyc(0, 0, 1, 1, 0, '0); check("R9 wrap", arr_addr, 20'hABC01);

        // R10: hold with adv low
        cyc(0, 0, 1, 0, 1, 20'h0);
        check("R10 hold", arr_addr, 20'hABC01);
        check("R10 hold write", AW'(arr_write), '0);

        // R3 + R8: controller write load, interleaved order
        order_linear = 1'b0;
        cyc(0, 1, 1, 0, 1, 20'h5FFF1);
        check("R3 addr", arr_addr, 20'h5FFF1);
        check("R3 write", AW'(arr_write), 20'h1);
        cyc(0, 0, 1, 1, 1, '0); check("R8 beat1", arr_addr, 20'h5FFF0);
        cyc(0, 0, 1, 1, 1, '0); check("R8 beat2", arr_addr, 20'h5FFF3);
        cyc(0, 0, 1, 1, 1, '0); check("R8 beat3", arr_addr, 20'h5FFF2);
        cyc(0, 0, 1, 1, 1, '0); check("R9 upper fixed", arr_addr, 20'h5FFF1);

        // R12: reload mid-burst
        cyc(0, 0, 1, 1, 1, '0);
        cyc(0, 1, 1, 0, 0, 20'h00302);
        check("R12 restart", arr_addr, 20'h00302);

        // R4: both strobes, processor wins
        cyc(1, 1, 1, 0, 1, 20'h77777);
        check("R4 write", AW'(arr_write), '0);
        check("R4 addr", arr_addr, 20'h77777);

        // R5: processor strobe ignored without chip enable
        cyc(0, 0, 1, 1, 1, '0);
        cyc(1, 0, 0, 0, 1, 20'h11111);
        check("R5 addr", arr_addr, exp_addr(20'h77777, 2'd1, 1'b0));
        check("R5 valid", AW'(arr_valid), 20'h1);

        // R6: deselect
        cyc(1, 1, 0, 0, 1, 20'h22222);
        check("R6 valid", AW'(arr_valid), '0);
        check("R6 write", AW'(arr_write), '0);

        // random mix against the model (R7/R8/R10 by mode)
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            if (i % 200 == 0) order_linear = 1'($urandom);
            cyc(r[7:6] == 2'b00, r[5:4] == 2'b00, r[3:1] != 3'b000, r[0], 1'($urandom), AW'($urandom));
            check_model(order_linear ? "R7 random" : "R8 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule